// File: doc/BRIEF.md
# Windowed Framebuffer Write Address Generator

This block turns a stream of pixel bytes into write cycles for a packed 4-bit grayscale display memory. The memory is organised as 64 byte-columns by 80 rows, and each byte carries two pixels. A rectangular write window is programmed with separate column and row loads. Each load supplies a start and an end value, and the load also moves the current position to the start. Every accepted data byte is written at the current position. The position then steps through the window.

The stepping order depends on a mode input. With the mode low, the pointer moves along columns first and drops to the next row at the column end. With the mode high, it moves down rows first and moves to the next column at the row end. In both orders the pointer wraps back inside the window. A sticky redraw flag reports that the memory has changed since the last completed display scan. The command decoder that produces the window loads sits outside this block, and so does the memory array.

Top module: `fbWinAddr`

## Requirements
- R1: After reset, wrEn and redraw are 0. The window covers columns 0..63 and rows 0..79, and the current position is column 0, row 0, so the first accepted byte is written at address 0.
- R2: The write address equals column + 64 × row. wrData carries the accepted byte unchanged, with both 4-bit pixels in their original positions.
- R3: wrEn, wrAddr and wrData are registered. wrEn is high for exactly one cycle, in the cycle after each accepted data strobe, and is low at all other times.
- R4: A column load takes its start value modulo 64 and its end value modulo 64. The current column becomes the reduced start value.
- R5: A row load takes its start value modulo 80 and its end value modulo 80. The current row becomes the reduced start value. A column load and a row load in the same cycle both take effect.
- R6: With vertMode = 0, the column increments after each write. A column beyond the column end returns to the column start and the row increments. A row beyond the row end then returns to the row start.
- R7: With vertMode = 1, the row increments after each write. A row beyond the row end returns to the row start and the column increments. A column beyond the column end then returns to the column start.
- R8: redraw is set by every accepted write and stays set until scanDone. If scanDone coincides with an accepted write, redraw stays set.
- R9: A data strobe that arrives in the same cycle as a column load or a row load is discarded: no write occurs, and the position is the one given by the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataStb | input | 1 | Pixel byte valid |
| dataByte | input | 8 | Two packed 4-bit pixels |
| colLoad | input | 1 | Load the column window from winStart/winEnd |
| rowLoad | input | 1 | Load the row window from winStart/winEnd |
| winStart | input | 8 | Window start value (reduced on load) |
| winEnd | input | 8 | Window end value (reduced on load) |
| vertMode | input | 1 | 0 = column-first order, 1 = row-first order |
| scanDone | input | 1 | Display scan finished; clears redraw |
| wrEn | output | 1 | Memory write enable |
| wrAddr | output | 13 | Memory byte address |
| wrData | output | 8 | Memory write data |
| redraw | output | 1 | Sticky flag: memory changed since the last scan |

## Verification
A plain run from reset walks addresses 0, 1, 2, and so on. This separates the address formula and the reset values from a wrong multiplier or wrong start values. Directed loads with values above 64 and above 80, followed by writes, show whether the modulo reduction is applied per axis.

A 2×2 window at the far corner is stepped in both modes. This separates the wrap order of the two axes and shows whether the second axis is wrapped after it increments. Randomized stimulus mixes strobes that collide with loads, start values above end values, mode flips in the middle of a stream and scanDone pulses. These are compared against a reference model. This exposes priority errors, lost writes and faults in the redraw flag.

// File: rtl/fbWinPkg.sv
package fbWinPkg;
  localparam int FB_COLS = 64;
  localparam int FB_ROWS = 80;
  localparam int FB_BYTE_W = 8;

  typedef struct packed {
    logic loadCol;
    logic loadRow;
    logic step;
    logic markDirty;
    logic clearDirty;
  } ctlStrobes_t;
endpackage

// File: rtl/fbWinCtrl.sv
module fbWinCtrl
  import fbWinPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataStb,
  input  logic        colLoad,
  input  logic        rowLoad,
  input  logic        scanDone,
  output ctlStrobes_t strobes,
  output logic        wrEn,
  output logic        redraw
);
  logic anyLoad;
  logic accept;

  // Window loads take precedence; a colliding byte is dropped.
  assign anyLoad = colLoad | rowLoad;
  assign accept  = dataStb & ~anyLoad;

  always_comb begin
    strobes.loadCol    = colLoad;
    strobes.loadRow    = rowLoad;
    strobes.step       = accept;
    strobes.markDirty  = accept;
    strobes.clearDirty = scanDone & ~accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      redraw <= 1'b0;
    end else begin
      wrEn <= strobes.step;
      if (strobes.markDirty) begin
        redraw <= 1'b1;
      end else if (strobes.clearDirty) begin
        redraw <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbWinPath.sv
module fbWinPath
  import fbWinPkg::*;
#(
  parameter int COLS   = FB_COLS,
  parameter int ROWS   = FB_ROWS,
  parameter int BYTE_W = FB_BYTE_W,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [BYTE_W-1:0] dataByte,
  input  logic [BYTE_W-1:0] winStart,
  input  logic [BYTE_W-1:0] winEnd,
  input  logic              vertMode,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  localparam int RED_STEPS = (2 ** BYTE_W) / ((COLS < ROWS) ? COLS : ROWS) + 1;

  // Reduce a raw byte modulo m by bounded repeated subtraction.
  function automatic logic [BYTE_W-1:0] reduceMod(input logic [BYTE_W-1:0] v, input int m);
    logic [BYTE_W-1:0] r;
    r = v;
    for (int i = 0; i < RED_STEPS; i++) begin
      if (int'(r) >= m) r = r - BYTE_W'(m);
    end
    return r;
  endfunction

  logic [COL_W-1:0] col, colStart, colEnd;
  logic [ROW_W-1:0] row, rowStart, rowEnd;
  logic [COL_W-1:0] colStartIn, colEndIn;
  logic [ROW_W-1:0] rowStartIn, rowEndIn;

  assign colStartIn = COL_W'(reduceMod(winStart, COLS));
  assign colEndIn   = COL_W'(reduceMod(winEnd, COLS));
  assign rowStartIn = ROW_W'(reduceMod(winStart, ROWS));
  assign rowEndIn   = ROW_W'(reduceMod(winEnd, ROWS));

  // Next position for both stepping orders.
  logic [COL_W:0] colInc;
  logic [ROW_W:0] rowInc;
  logic [COL_W-1:0] hCol, vCol, nextCol;
  logic [ROW_W-1:0] hRow, vRow, nextRow;
  logic [ROW_W:0] hRowPre;
  logic [COL_W:0] vColPre;
  logic hColWrap, vRowWrap;

  assign colInc = {1'b0, col} + 1'b1;
  assign rowInc = {1'b0, row} + 1'b1;

  always_comb begin
    // column-first
    hColWrap = colInc > {1'b0, colEnd};
    hCol     = hColWrap ? colStart : colInc[COL_W-1:0];
    hRowPre  = hColWrap ? rowInc : {1'b0, row};
    hRow     = (hRowPre > {1'b0, rowEnd}) ? rowStart : hRowPre[ROW_W-1:0];
    // row-first
    vRowWrap = rowInc > {1'b0, rowEnd};
    vRow     = vRowWrap ? rowStart : rowInc[ROW_W-1:0];
    vColPre  = vRowWrap ? colInc : {1'b0, col};
    vCol     = (vColPre > {1'b0, colEnd}) ? colStart : vColPre[COL_W-1:0];
    nextCol  = vertMode ? vCol : hCol;
    nextRow  = vertMode ? vRow : hRow;
  end

  logic [ADDR_W-1:0] curAddr;
  assign curAddr = ADDR_W'(col) + ADDR_W'(row) * ADDR_W'(COLS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      col      <= '0;
      colStart <= '0;
      colEnd   <= COL_W'(COLS - 1);
      row      <= '0;
      rowStart <= '0;
      rowEnd   <= ROW_W'(ROWS - 1);
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      if (strobes.loadCol) begin
        col      <= colStartIn;
        colStart <= colStartIn;
        colEnd   <= colEndIn;
      end
      if (strobes.loadRow) begin
        row      <= rowStartIn;
        rowStart <= rowStartIn;
        rowEnd   <= rowEndIn;
      end
      if (strobes.step) begin
        wrAddr <= curAddr;
        wrData <= dataByte;
        col    <= nextCol;
        row    <= nextRow;
      end
    end
  end
endmodule

// File: rtl/fbWinAddr.sv
module fbWinAddr
  import fbWinPkg::*;
#(
  parameter int COLS   = FB_COLS,
  parameter int ROWS   = FB_ROWS,
  parameter int BYTE_W = FB_BYTE_W,
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataStb,
  input  logic [BYTE_W-1:0] dataByte,
  input  logic              colLoad,
  input  logic              rowLoad,
  input  logic [BYTE_W-1:0] winStart,
  input  logic [BYTE_W-1:0] winEnd,
  input  logic              vertMode,
  input  logic              scanDone,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              redraw
);
  ctlStrobes_t strobes;

  fbWinCtrl uCtrl (
    .clk(clk), .rstN(rstN), .dataStb(dataStb), .colLoad(colLoad),
    .rowLoad(rowLoad), .scanDone(scanDone), .strobes(strobes),
    .wrEn(wrEn), .redraw(redraw)
  );

  fbWinPath #(.COLS(COLS), .ROWS(ROWS), .BYTE_W(BYTE_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataByte(dataByte),
    .winStart(winStart), .winEnd(winEnd), .vertMode(vertMode),
    .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/fbWinChecker.sv
module fbWinChecker #(
  parameter int COLS   = 64,
  parameter int ROWS   = 80,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              dataStb,
  input logic [BYTE_W-1:0] dataByte,
  input logic              colLoad,
  input logic              rowLoad,
  input logic              vertMode,
  input logic              scanDone,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BYTE_W-1:0] wrData,
  input logic              redraw
);
  assert_write_follows_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataStb && !colLoad && !rowLoad) |=> wrEn);

  assert_write_has_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(dataStb));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataStb && (colLoad || rowLoad)) |=> !wrEn);

  assert_data_passthrough_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData == $past(dataByte)));

  assert_addr_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (int'(wrAddr) < COLS * ROWS));

  assert_write_marks_dirty_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> redraw);

  assert_scan_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !(dataStb && !colLoad && !rowLoad)) |=> !redraw);

  assert_dirty_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (redraw && !scanDone) |=> redraw);
endmodule

bind fbWinAddr fbWinChecker #(.COLS(COLS), .ROWS(ROWS), .BYTE_W(BYTE_W)) uChk (.*);

// File: tb/sim_fbWinAddr.sv
`timescale 1ns/1ps
module sim_fbWinAddr;
  logic clk = 1'b0;
  logic rstN;
  logic dataStb, colLoad, rowLoad, vertMode, scanDone;
  logic [7:0] dataByte, winStart, winEnd;
  logic wrEn, redraw;
  logic [12:0] wrAddr;
  logic [7:0] wrData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // reference model state
  int mCol, mColS, mColE, mRow, mRowS, mRowE;
  bit mRedraw;

  always #2.5 clk = ~clk;

  fbWinAddr u0 (
    .clk(clk), .rstN(rstN), .dataStb(dataStb), .dataByte(dataByte),
    .colLoad(colLoad), .rowLoad(rowLoad), .winStart(winStart), .winEnd(winEnd),
    .vertMode(vertMode), .scanDone(scanDone), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .redraw(redraw)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    mCol = 0; mColS = 0; mColE = 63;
    mRow = 0; mRowS = 0; mRowE = 79;
    mRedraw = 0;
  endfunction

  function automatic void modelStep(input bit vert);
    if (!vert) begin
      mCol++;
      if (mCol > mColE) begin mCol = mColS; mRow++; end
      if (mRow > mRowE) mRow = mRowS;
    end else begin
      mRow++;
      if (mRow > mRowE) begin mRow = mRowS; mCol++; end
      if (mCol > mColE) mCol = mColS;
    end
  endfunction

  // One clock of stimulus with checks on the registered result.
  task automatic cyc(input bit stb, input logic [7:0] b, input bit cl, input bit rl,
                     input logic [7:0] s, input logic [7:0] e, input bit vert, input bit scan);
    bit acc;
    int expAddr;
    @(negedge clk);
    dataStb = stb; dataByte = b; colLoad = cl; rowLoad = rl;
    winStart = s; winEnd = e; vertMode = vert; scanDone = scan;
    acc = stb && !cl && !rl;
    expAddr = mCol + 64 * mRow;
    if (cl) begin mColS = s % 64; mColE = e % 64; mCol = mColS; end
    if (rl) begin mRowS = s % 80; mRowE = e % 80; mRow = mRowS; end
    if (acc) begin modelStep(vert); mRedraw = 1; end
    else if (scan) mRedraw = 0;
    @(posedge clk);
    #1;
    chk(cl || rl ? "R9 wrEn" : "R3 wrEn", int'(wrEn), int'(acc));
    if (acc) begin
      chk(vert ? "R7 wrAddr" : "R6 wrAddr", int'(wrAddr), expAddr);
      chk("R2 wrData", int'(wrData), int'(b));
    end
    chk("R8 redraw", int'(redraw), int'(mRedraw));
  endtask

  task automatic idle();
    cyc(0, 8'h00, 0, 0, 8'h00, 8'h00, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; dataStb = 0; dataByte = 0; colLoad = 0; rowLoad = 0;
    winStart = 0; winEnd = 0; vertMode = 0; scanDone = 0;
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1;
    @(posedge clk); #1;
    chk("R1 wrEn reset", int'(wrEn), 0);
    chk("R1 redraw reset", int'(redraw), 0);

    // R1/R2: linear run from reset gives addresses 0,1,2,3
    for (int i = 0; i < 4; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, 0, 0, 0, 0);
    // R3: idle cycle after writes, wrEn drops
    idle();
    // R8: scan clears, coincident write keeps set
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(1, 8'h5C, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);

    // R4/R5: reduced loads (126%64=62, 255%64=63, 158%80=78, 239%80=79)
    cyc(0, 0, 1, 0, 8'd126, 8'd255, 0, 0);
    cyc(0, 0, 0, 1, 8'd158, 8'd239, 0, 0);
    // R6: 2x2 corner window, column-first
    for (int i = 0; i < 5; i++) cyc(1, 8'(i), 0, 0, 0, 0, 0, 0);
    // R7: reload and step row-first
    cyc(0, 0, 1, 1, 8'd62, 8'd63, 0, 0);
    cyc(0, 0, 0, 1, 8'd78, 8'd79, 1, 0);
    for (int i = 0; i < 5; i++) cyc(1, 8'(i + 16), 0, 0, 0, 0, 1, 0);
    // R9: collision with load, then write lands at load start
    cyc(1, 8'hEE, 1, 0, 8'd10, 8'd20, 0, 0);
    cyc(1, 8'hEF, 0, 1, 8'd5, 8'd6, 0, 0);
    cyc(1, 8'h11, 0, 0, 0, 0, 0, 0);

    // randomized mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit stb = (r < 65);
      bit cl = ($urandom_range(0, 99) < 6);
      bit rl = ($urandom_range(0, 99) < 6);
      bit sc = ($urandom_range(0, 99) < 10);
      bit vt = ($urandom_range(0, 199) < 100) ? vertMode : ~vertMode;
      cyc(stb, 8'($urandom), cl, rl, 8'($urandom), 8'($urandom), vt, sc);
    end
    idle();

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule